// File: doc/BRIEF.md
# Shared-Ring Time-to-Digital Stamp Encoder

This block is the digital back end of a time-to-digital converter that several pixel channels share. A gated ring oscillator of 15 stages runs only while a measurement is open. Its tap outputs arrive on the `taps` port once per clock. The block turns each tap sample into a fine phase code from 0 to 14 and counts completed ring revolutions in a coarse counter. When a channel reports its stop event, the block stores the joined coarse and fine values as that channel's timestamp.

A measurement opens on the rising edge of `start`, which also clears every channel slot, the lap count and the flags. All timestamps are therefore measured from that event. Each channel keeps only its first stop edge of the measurement. Software or a downstream sequencer reads the slots one at a time through `rd_sel`. The readout is combinational, so it needs no extra cycle.

Top module: `tdc_stamp_hub`

## Requirements
- R1: After reset every channel reads `rd_valid` 0 and `rd_stamp` 0, and `coarse_ovf` and `tap_err` are 0.
- R2: Tap bit i is inverted when i is odd, giving a normalized vector n. The fine code is the length of the run of bits, starting at bit 0, that equal n[0]. A run covering all 15 bits gives fine code 0.
- R3: If n is not one run followed only by the opposite value, the fine code is 15 (reserved). `tap_err` then goes to 1 at the first clock edge that samples such taps during an open measurement, and it stays 1 until the next measurement opens.
- R4: During an open measurement the coarse count rises by one whenever the fine code of a valid tap sample is smaller than that of the valid sample one clock earlier. With a ring phase p counted from 0 at the opening edge, the coarse count is floor(p/15).
- R5: The coarse count saturates at 15 and does not wrap. A revolution that completes while the count is already 15 sets `coarse_ovf`, and `coarse_ovf` then holds until the next measurement opens.
- R6: A stamp holds the coarse count in bits [7:4] and the fine code in bits [3:0]. It is taken at the clock edge where the stop rising edge is sampled, using the taps of that edge and a coarse count that already includes a revolution completed at that edge.
- R7: A channel accepts only its first rising stop edge per measurement. Later edges, and a stop held high, leave its stamp unchanged until the next measurement opens.
- R8: A channel with no accepted stop reads `rd_valid` 0 and `rd_stamp` 0.
- R9: A rising `start` clears all slots and flags. Stop edges are accepted only while `start` is high, after the opening clock edge. A stop edge sampled at the opening edge, or while `start` is low, is ignored, and stamps hold after `start` falls.
- R10: Stops on several channels at the same edge all receive the same stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Measurement window; its rising edge opens a measurement |
| taps | input | 15 | Sampled ring tap vector |
| stop | input | N_CH | Per-channel stop events, rising-edge sensitive |
| rd_sel | input | SEL_W | Channel chosen for readout |
| rd_stamp | output | 8 | Stamp of the chosen channel, 0 when empty |
| rd_valid | output | 1 | Chosen channel holds a stamp |
| coarse_ovf | output | 1 | Coarse count ran past its maximum |
| tap_err | output | 1 | Invalid tap pattern seen in this measurement |

## Verification
A stop edge sampled at clock edge N shows on the readout straight after edge N. It carries the taps driven for edge N and the lap count including any revolution completed at N. `tap_err` and `coarse_ovf` also change at the edge that samples the offending taps. The opening edge clears everything in the same step. The bench changes inputs on the falling edge, lets one rising edge pass, and reads results at the next falling edge after a 1 ns settle on `rd_sel`. Each expected stamp comes from the ring phase the bench itself drove.

// File: rtl/tdc_stamp_pkg.sv
`timescale 1ns/1ps
package tdc_stamp_pkg;
  localparam int TAP_N    = 15;
  localparam int FINE_W   = $clog2(TAP_N + 1);
  localparam int COARSE_W = 4;
  localparam int STAMP_W  = COARSE_W + FINE_W;

  typedef logic [TAP_N-1:0]    taps_t;
  typedef logic [FINE_W-1:0]   fine_t;
  typedef logic [COARSE_W-1:0] coarse_t;
  typedef logic [STAMP_W-1:0]  stamp_t;

  localparam fine_t   FINE_BAD   = '1;
  localparam coarse_t COARSE_MAX = '1;

  typedef struct packed {
    logic  ok;
    fine_t fine;
  } enc_t;

  // Odd taps of an inverter ring carry the opposite polarity.
  function automatic taps_t polarity_mask();
    taps_t m;
    for (int i = 0; i < TAP_N; i++) m[i] = ((i % 2) == 1);
    return m;
  endfunction

  function automatic int run_length(taps_t n);
    int   run;
    logic same;
    run  = 0;
    same = 1'b1;
    for (int i = 0; i < TAP_N; i++) begin
      if (same && (n[i] == n[0])) run++;
      else same = 1'b0;
    end
    return run;
  endfunction

  function automatic enc_t encode_taps(taps_t raw);
    taps_t n;
    int    run;
    enc_t  e;
    n    = raw ^ polarity_mask();
    run  = run_length(n);
    e.ok = 1'b1;
    for (int i = 0; i < TAP_N; i++) begin
      if (n[i] != ((i < run) ? n[0] : ~n[0])) e.ok = 1'b0;
    end
    if (!e.ok)             e.fine = FINE_BAD;
    else if (run == TAP_N) e.fine = '0;
    else                   e.fine = fine_t'(run);
    return e;
  endfunction

  function automatic coarse_t sat_inc(coarse_t c);
    return (c == COARSE_MAX) ? c : c + 1'b1;
  endfunction

  function automatic stamp_t join_stamp(coarse_t c, fine_t f);
    return {c, f};
  endfunction
endpackage

// File: rtl/tdc_tap_encoder.sv
`timescale 1ns/1ps
module tdc_tap_encoder
  import tdc_stamp_pkg::*;
(
  input  taps_t taps,
  output fine_t fine,
  output logic  ok
);
  enc_t enc;
  assign enc  = encode_taps(taps);
  assign fine = enc.fine;
  assign ok   = enc.ok;
endmodule

// File: rtl/tdc_lap_counter.sv
`timescale 1ns/1ps
module tdc_lap_counter
  import tdc_stamp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clear,
  input  logic    active,
  input  fine_t   fine_now,
  input  logic    ok_now,
  output logic    lap,
  output coarse_t coarse_q,
  output coarse_t coarse_eff,
  output logic    ovf_q
);
  fine_t fine_prev;
  logic  ok_prev;

  // A revolution shows as the fine phase falling back between two good samples.
  assign lap = active && ok_now && ok_prev && (fine_now < fine_prev);

  always_comb begin
    if (clear)    coarse_eff = '0;
    else if (lap) coarse_eff = sat_inc(coarse_q);
    else          coarse_eff = coarse_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fine_prev <= '0;
      ok_prev   <= 1'b0;
      coarse_q  <= '0;
      ovf_q     <= 1'b0;
    end else begin
      fine_prev <= fine_now;
      ok_prev   <= ok_now;
      coarse_q  <= coarse_eff;
      if (clear) ovf_q <= 1'b0;
      else if (lap && (coarse_q == COARSE_MAX)) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tdc_latch_bank.sv
`timescale 1ns/1ps
module tdc_latch_bank
  import tdc_stamp_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                active,
  input  logic [N_CH-1:0]     stop_edge,
  input  stamp_t              stamp_in,
  output logic [N_CH-1:0]     valid,
  output stamp_t [N_CH-1:0]   slot
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic   v_q;
    stamp_t s_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        v_q <= 1'b0;
        s_q <= '0;
      end else if (active && stop_edge[c] && !v_q) begin
        v_q <= 1'b1;
        s_q <= stamp_in;
      end
    end
    assign valid[c] = v_q;
    assign slot[c]  = s_q;
  end
endmodule

// File: rtl/tdc_stamp_hub.sv
`timescale 1ns/1ps
module tdc_stamp_hub
  import tdc_stamp_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [TAP_N-1:0]   taps,
  input  logic [N_CH-1:0]    stop,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [STAMP_W-1:0] rd_stamp,
  output logic               rd_valid,
  output logic               coarse_ovf,
  output logic               tap_err
);
  logic                start_q;
  logic [N_CH-1:0]     stop_q;
  logic                start_rise;
  logic                active;
  logic [N_CH-1:0]     stop_edge;
  fine_t               enc_fine;
  logic                enc_ok;
  logic                lap;
  coarse_t             coarse_q;
  coarse_t             coarse_eff;
  stamp_t              stamp_now;
  logic [N_CH-1:0]     valid_vec;
  stamp_t [N_CH-1:0]   slot;
  logic                err_q;

  assign start_rise = start && !start_q;
  assign active     = start && start_q;
  assign stop_edge  = stop & ~stop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      stop_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      start_q <= start;
      stop_q  <= stop;
      if (start_rise) err_q <= 1'b0;
      else if (active && !enc_ok) err_q <= 1'b1;
    end
  end

  tdc_tap_encoder u_enc (
    .taps (taps),
    .fine (enc_fine),
    .ok   (enc_ok)
  );

  tdc_lap_counter u_lap (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_rise),
    .active     (active),
    .fine_now   (enc_fine),
    .ok_now     (enc_ok),
    .lap        (lap),
    .coarse_q   (coarse_q),
    .coarse_eff (coarse_eff),
    .ovf_q      (coarse_ovf)
  );

  assign stamp_now = join_stamp(coarse_eff, enc_fine);

  tdc_latch_bank #(.N_CH(N_CH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_rise),
    .active    (active),
    .stop_edge (stop_edge),
    .stamp_in  (stamp_now),
    .valid     (valid_vec),
    .slot      (slot)
  );

  always_comb begin
    rd_valid = 1'b0;
    rd_stamp = '0;
    if (int'(rd_sel) < N_CH) begin
      if (valid_vec[rd_sel]) begin
        rd_valid = 1'b1;
        rd_stamp = slot[rd_sel];
      end
    end
  end

  assign tap_err = err_q;
endmodule

// File: rtl/tdc_stamp_hub_chk.sv
`timescale 1ns/1ps
module tdc_stamp_hub_chk
  import tdc_stamp_pkg::*;
#(
  parameter int N_CH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_rise,
  input logic               active,
  input logic               lap,
  input logic               enc_ok,
  input logic [FINE_W-1:0]  enc_fine,
  input logic [COARSE_W-1:0] coarse_q,
  input logic               coarse_ovf,
  input logic               tap_err,
  input logic [N_CH-1:0]    valid_vec,
  input logic               rd_valid,
  input logic [STAMP_W-1:0] rd_stamp
);
  p_fine_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enc_ok |-> (int'(enc_fine) < TAP_N));

  p_bad_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_ok |-> (enc_fine == FINE_BAD));

  p_err_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !enc_ok) |=> tap_err);

  p_lap_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lap |-> active);

  p_coarse_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !start_rise |=> (coarse_q >= $past(coarse_q)));

  p_ovf_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_ovf |-> (coarse_q == COARSE_MAX));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_rise |=> ((valid_vec & $past(valid_vec)) == $past(valid_vec)));

  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_stamp == '0));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |=> ((valid_vec == '0) && !coarse_ovf && !tap_err));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start_rise) |=> $stable(valid_vec));
endmodule

bind tdc_stamp_hub tdc_stamp_hub_chk #(.N_CH(N_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_rise (start_rise),
  .active     (active),
  .lap        (lap),
  .enc_ok     (enc_ok),
  .enc_fine   (enc_fine),
  .coarse_q   (coarse_q),
  .coarse_ovf (coarse_ovf),
  .tap_err    (tap_err),
  .valid_vec  (valid_vec),
  .rd_valid   (rd_valid),
  .rd_stamp   (rd_stamp)
);

// File: tb/tdc_stamp_hub_test.sv
`timescale 1ns/1ps
module tdc_stamp_hub_test;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [14:0] taps;
  logic [3:0]  stop;
  logic [1:0]  rd_sel;
  logic [7:0]  rd_stamp;
  logic        rd_valid;
  logic        coarse_ovf;
  logic        tap_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tdc_stamp_hub #(.N_CH(NCH)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .taps       (taps),
    .stop       (stop),
    .rd_sel     (rd_sel),
    .rd_stamp   (rd_stamp),
    .rd_valid   (rd_valid),
    .coarse_ovf (coarse_ovf),
    .tap_err    (tap_err)
  );

  // Ring phase p: front at p mod 15, polarity flips every 15 steps; odd taps inverted.
  function automatic logic [14:0] ring_taps(int p);
    logic [14:0] r;
    int k;
    bit flip;
    k = p % 15;
    flip = ((p / 15) % 2) == 1;
    for (int i = 0; i < 15; i++) r[i] = ((i < k) ^ flip) ^ (i % 2 == 1);
    return r;
  endfunction

  function automatic int exp_stamp(int p);
    int c;
    c = p / 15;
    if (c > 15) c = 15;
    return c * 16 + (p % 15);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic st, input logic [14:0] tv, input logic [3:0] sv);
    start = st;
    taps  = tv;
    stop  = sv;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_ch(input int ch, output int v, output int s);
    rd_sel = 2'(ch);
    #1;
    v = int'(rd_valid);
    s = int'(rd_stamp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, ring_taps(0), 4'b0000);
  endtask

  // Open a measurement at phase 0, advance nsteps by stride, then stop on smask.
  task automatic sweep_to(input int stride, input int nsteps, input logic [3:0] smask);
    idle(1);
    cyc(1'b1, ring_taps(0), 4'b0000);
    for (int i = 1; i <= nsteps; i++) cyc(1'b1, ring_taps(stride * i), 4'b0000);
    cyc(1'b1, ring_taps(stride * nsteps), smask);
    cyc(1'b1, ring_taps(stride * nsteps), 4'b0000);
  endtask

  task automatic t_reset();
    int v, s;
    for (int c = 0; c < NCH; c++) begin
      read_ch(c, v, s);
      check("R1", "valid after reset", v, 0);
      check("R1", "stamp after reset", s, 0);
    end
    check("R1", "overflow after reset", int'(coarse_ovf), 0);
    check("R1", "tap error after reset", int'(tap_err), 0);
  endtask

  task automatic t_encode_sweep();
    int v, s;
    for (int t = 0; t < 30; t++) begin
      sweep_to(1, t, 4'b0001);
      read_ch(0, v, s);
      check("R2", $sformatf("valid at phase %0d", t), v, 1);
      check("R6", $sformatf("stamp at phase %0d", t), s, exp_stamp(t));
    end
    read_ch(1, v, s);
    check("R8", "idle channel valid", v, 0);
    check("R8", "idle channel stamp", s, 0);
    idle(1);
  endtask

  task automatic t_stride();
    int v, s;
    sweep_to(7, 10, 4'b0010);
    read_ch(1, v, s);
    check("R4", "stride 7 lap count", s, exp_stamp(70));
    sweep_to(13, 9, 4'b0010);
    read_ch(1, v, s);
    check("R4", "stride 13 lap count", s, exp_stamp(117));
    idle(1);
  endtask

  task automatic t_saturate();
    int v, s;
    idle(1);
    cyc(1'b1, ring_taps(0), 4'b0000);
    for (int i = 1; i <= 16; i++) cyc(1'b1, ring_taps(14 * i), 4'b0000);
    cyc(1'b1, ring_taps(14 * 17), 4'b0010);
    check("R5", "no overflow at count 15", int'(coarse_ovf), 0);
    read_ch(1, v, s);
    check("R5", "stamp at count 15", s, exp_stamp(238));
    cyc(1'b1, ring_taps(14 * 18), 4'b0000);
    check("R5", "overflow past 15", int'(coarse_ovf), 1);
    cyc(1'b1, ring_taps(14 * 19), 4'b0000);
    cyc(1'b1, ring_taps(14 * 20), 4'b0100);
    read_ch(2, v, s);
    check("R5", "saturated stamp", s, exp_stamp(280));
    check("R5", "overflow holds", int'(coarse_ovf), 1);
    idle(1);
  endtask

  task automatic t_first_only();
    int v, s;
    logic [3:0] sv;
    idle(1);
    cyc(1'b1, ring_taps(0), 4'b0000);
    for (int i = 1; i <= 10; i++) begin
      sv = 4'b0000;
      if (i == 3 || i == 8) sv[2] = 1'b1;
      if (i >= 4) sv[3] = 1'b1;
      cyc(1'b1, ring_taps(i), sv);
    end
    read_ch(2, v, s);
    check("R7", "second pulse ignored", s, exp_stamp(3));
    read_ch(3, v, s);
    check("R7", "held stop latched once", s, exp_stamp(4));
    cyc(1'b0, ring_taps(11), 4'b0000);
    cyc(1'b0, ring_taps(12), 4'b0001);
    read_ch(0, v, s);
    check("R9", "stop while start low", v, 0);
    read_ch(2, v, s);
    check("R9", "stamp holds after start falls", s, exp_stamp(3));
  endtask

  task automatic t_restart();
    int v, s;
    idle(1);
    cyc(1'b1, ring_taps(0), 4'b0010);
    cyc(1'b1, ring_taps(1), 4'b0010);
    read_ch(1, v, s);
    check("R9", "stop at opening edge ignored", v, 0);
    read_ch(2, v, s);
    check("R9", "old slot cleared", v, 0);
    check("R9", "overflow cleared", int'(coarse_ovf), 0);
    cyc(1'b1, ring_taps(2), 4'b0000);
    cyc(1'b1, ring_taps(3), 4'b0010);
    read_ch(1, v, s);
    check("R9", "fresh stop accepted", s, exp_stamp(3));
    idle(1);
  endtask

  task automatic t_bad_taps();
    int v, s;
    logic [14:0] bad;
    bad = 15'b000_0000_0000_0101 ^ 15'b010_1010_1010_1010;
    idle(1);
    cyc(1'b1, ring_taps(0), 4'b0000);
    cyc(1'b1, ring_taps(1), 4'b0000);
    check("R3", "no error on clean taps", int'(tap_err), 0);
    cyc(1'b1, bad, 4'b1000);
    check("R3", "error flag raised", int'(tap_err), 1);
    read_ch(3, v, s);
    check("R3", "reserved fine code", s, 15);
    cyc(1'b1, ring_taps(2), 4'b0000);
    check("R3", "error flag sticky", int'(tap_err), 1);
    idle(1);
    cyc(1'b1, ring_taps(0), 4'b0000);
    check("R3", "error cleared by new start", int'(tap_err), 0);
    idle(1);
  endtask

  task automatic t_simul();
    int v, s;
    sweep_to(1, 20, 4'b1111);
    for (int c = 0; c < NCH; c++) begin
      read_ch(c, v, s);
      check("R10", $sformatf("shared stamp ch%0d", c), s, exp_stamp(20));
    end
    idle(1);
  endtask

  initial begin
    rst_n  = 1'b0;
    start  = 1'b0;
    taps   = '0;
    stop   = '0;
    rd_sel = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_encode_sweep();
    t_stride();
    t_saturate();
    t_first_only();
    t_restart();
    t_bad_taps();
    t_simul();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule